// File: doc/BRIEF.md
# Register-Mapped GPIO Controller

This block gives software a small word-addressed register window onto a set of general-purpose I/O lines. Through it, software reads the level on each line, drives individual lines high or low with write-one set and clear words, and chooses per line whether it is an output or an input. The pad buffers sit outside the block. They are represented as an output-data vector, an output-enable vector and an input vector, and the input vector is synchronised before software sees it.

Compile-time parameters fix the register width, and so the number of lines. Other parameters can reverse the line-to-bit order, swap the byte order of the bus word, remove the clear register (the set register then becomes a plain output register), and make a read of the set register return the output latch instead of the pins. The direction state has two registers of opposite polarity. Both are views of one stored vector, so the two can never disagree. Read data is combinational from the address. A write takes effect at the next rising clock edge.

Top module: `gpio_mmio_ctrl`

## Requirements
- R1: `REG_W` may be 8, 16, 32 or 64 and the block has exactly `REG_W` lines. Any other width, or `REG_W`=64 together with byte swapping, stops elaboration.
- R2: A read at word address 0 returns the level of every line, with 1 meaning high. A change on `pad_in` becomes visible to this read after two rising clock edges.
- R3: When the clear register is present, writing address 1 sets to 1 the output-latch bits written as 1 and keeps every latch bit written as 0.
- R4: When the clear register is present, writing address 2 forces to 0 the latch bits written as 1 and keeps the others. A read of address 2 returns zero.
- R5: When the clear register is absent, a write to address 1 loads the whole latch, so a 0 bit drives its line low. Address 2 then behaves as unmapped.
- R6: Address 3 holds the output-direction bits, where 1 means output. `pad_oe` equals this vector, and `pad_out` equals the output latch.
- R7: Address 4 is the input-direction view, where 1 means input. Writing it stores the complement as the direction, and reading it returns the complement of address 3.
- R8: With `MIRROR`=1, line i corresponds to register bit `REG_W`-1-i in every register, for both reads and writes.
- R9: With `BYTE_SWAP`=1, byte k of the bus word corresponds to byte `REG_W`/8-1-k of the register, for both reads and writes.
- R10: With `SET_READS_LATCH`=1, reading address 1 returns the output latch. With 0, it returns the line levels, the same as address 0.
- R11: Addresses 5 to 7 read as zero, and writes to them change no state.
- R12: After reset every line is an input (`pad_oe`=0) and the output latch is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Word address of the register accessed |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | REG_W | Write word |
| bus_rdata | output | REG_W | Read word for `bus_addr`, combinational |
| pad_in | input | REG_W | Levels seen at the pads |
| pad_out | output | REG_W | Value each pad drives when enabled |
| pad_oe | output | REG_W | Per-pad output enable, 1 = drive |

## Verification
The bench goes after the three places where this block usually goes wrong. The first is the write-one semantics: a set or clear that also touched bits written as 0 would corrupt neighbouring lines, which the bench detects by layering set and clear writes. The second is the direction pair: a design that kept two separate direction registers, or returned the same polarity on both addresses, would read the wrong value back from address 4 after address 3 was written, and the reverse. The third is the permutation. A second instance, 16 bits wide, runs with mirroring, byte swapping, no clear register and latch read-back. Because the expected pad values there are asymmetric, an inverted mirror or a missing swap shows up as a wrong output-enable or output pattern. The bench also checks that unmapped addresses neither return data nor disturb the latch and direction.

// File: rtl/gpio_pkg.sv
// Package: shared constants and index helpers for the GPIO controller.
// Assumes word addressing with a three-bit address.
package gpio_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_LEVEL = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_SET   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CLR   = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_DOUT  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_DIN   = 3'd4;

    // Bus bit index feeding line index i. The map is its own inverse.
    function automatic int perm_idx(int i, int w, bit mir, bit swp);
        int j;
        j = i;
        if (swp) j = (w / 8 - 1 - i / 8) * 8 + (i % 8);
        if (mir) j = w - 1 - j;
        return j;
    endfunction

endpackage

// File: rtl/gpio_lane_map.sv
// Module: fixed bit permutation between the bus word and the line vector.
// It applies the optional byte swap and the optional mirroring. The map is
// an involution, so the same module serves the write path and the read path.
module gpio_lane_map #(
    parameter int W         = 32,
    parameter bit MIRROR    = 1'b0,
    parameter bit BYTE_SWAP = 1'b0
) (
    input  logic [W-1:0] in_word,
    output logic [W-1:0] out_word
);
    for (genvar i = 0; i < W; i++) begin : g_lane
        localparam int SRC = gpio_pkg::perm_idx(i, W, MIRROR, BYTE_SWAP);
        assign out_word[i] = in_word[SRC];
    end
endmodule

// File: rtl/gpio_sync.sv
// Module: two-flop synchroniser for the pad inputs.
// Assumes each bit is independent. No multi-bit coherence is provided.
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Shift the pad levels through two stages, both cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_regs.sv
// Module: output latch and direction state, in line order.
// Assumes the write data is already permuted into line order. Direction is
// stored once, and the input-direction view is its complement.
module gpio_regs #(
    parameter int W       = 32,
    parameter bit HAS_CLR = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [gpio_pkg::ADDR_W-1:0] addr,
    input  logic [W-1:0]              wr_lines,
    output logic [W-1:0]              latch_q,
    output logic [W-1:0]              dir_q
);
    import gpio_pkg::*;

    // Update the output latch from set, clear, or whole-word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (we && addr == ADR_SET) begin
            latch_q <= HAS_CLR ? (latch_q | wr_lines) : wr_lines;
        end else if (we && addr == ADR_CLR && HAS_CLR) begin
            latch_q <= latch_q & ~wr_lines;
        end
    end

    // Update the direction from either polarity of direction write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (we && addr == ADR_DOUT) begin
            dir_q <= wr_lines;
        end else if (we && addr == ADR_DIN) begin
            dir_q <= ~wr_lines;
        end
    end

    // R12
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (latch_q == '0 && dir_q == '0));

    // R3
    set_drives_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADR_SET && HAS_CLR) |=>
            ((latch_q & $past(wr_lines)) == $past(wr_lines)));

    // R3
    set_keeps_zeros_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADR_SET && HAS_CLR) |=>
            ((latch_q & ~$past(wr_lines)) == ($past(latch_q) & ~$past(wr_lines))));

    // R4
    clr_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADR_CLR && HAS_CLR) |=>
            ((latch_q & $past(wr_lines)) == '0));

    // R5
    plain_set_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADR_SET && !HAS_CLR) |=> (latch_q == $past(wr_lines)));
endmodule

// File: rtl/gpio_mmio_ctrl.sv
// Module: top of the register-mapped GPIO controller.
// Assumes a single-cycle bus: read data is combinational from the address,
// and writes land at the next rising edge. Pads are external tri-state buffers.
module gpio_mmio_ctrl #(
    parameter int REG_W           = 32,
    parameter bit MIRROR          = 1'b0,
    parameter bit BYTE_SWAP       = 1'b0,
    parameter bit HAS_CLR         = 1'b1,
    parameter bit SET_READS_LATCH = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       bus_addr,
    input  logic             bus_we,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic [REG_W-1:0] pad_in,
    output logic [REG_W-1:0] pad_out,
    output logic [REG_W-1:0] pad_oe
);
    import gpio_pkg::*;

    localparam bit WIDTH_OK = (REG_W == 8) || (REG_W == 16) ||
                              (REG_W == 32) || (REG_W == 64);

    // Reject unsupported configurations at elaboration (R1).
    if (!WIDTH_OK) begin : g_bad_width
        $error("gpio_mmio_ctrl: REG_W must be 8, 16, 32 or 64");
    end
    if (BYTE_SWAP && REG_W == 64) begin : g_bad_swap
        $error("gpio_mmio_ctrl: byte swapping is not allowed at 64 bits");
    end

    logic [REG_W-1:0] wr_lines;
    logic [REG_W-1:0] rd_lines;
    logic [REG_W-1:0] latch_q;
    logic [REG_W-1:0] dir_q;
    logic [REG_W-1:0] pin_q;

    gpio_lane_map #(.W(REG_W), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP)) u_wmap (
        .in_word (bus_wdata),
        .out_word(wr_lines)
    );

    gpio_regs #(.W(REG_W), .HAS_CLR(HAS_CLR)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bus_we),
        .addr    (bus_addr),
        .wr_lines(wr_lines),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    gpio_sync #(.W(REG_W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pad_in),
        .q    (pin_q)
    );

    // Select the line-order value of the register being read.
    always_comb begin
        rd_lines = '0;
        case (bus_addr)
            ADR_LEVEL: rd_lines = pin_q;
            ADR_SET:   rd_lines = SET_READS_LATCH ? latch_q : pin_q;
            ADR_DOUT:  rd_lines = dir_q;
            ADR_DIN:   rd_lines = ~dir_q;
            default:   rd_lines = '0;
        endcase
    end

    gpio_lane_map #(.W(REG_W), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP)) u_rmap (
        .in_word (rd_lines),
        .out_word(bus_rdata)
    );

    assign pad_out = latch_q;
    assign pad_oe  = dir_q;

    // R11
    unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > ADR_DIN) |-> (bus_rdata == '0));

    // R11
    unmapped_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr > ADR_DIN) |=> ($stable(pad_oe) && $stable(pad_out)));

    // R6
    oe_holds_without_dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (bus_addr == ADR_DOUT || bus_addr == ADR_DIN)) |=> $stable(pad_oe));
endmodule

// File: tb/sim_gpio_mmio_ctrl.sv
// Bench: scoreboard for two configurations of the GPIO controller.
// u0 is 32 bits wide in plain order with a clear register. u1 is 16 bits wide,
// mirrored and byte-swapped, with no clear register and latch read-back.
module sim_gpio_mmio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic        we0 = 1'b0;
    logic        we1 = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata0;
    logic [15:0] rdata1;
    logic [31:0] pin0, pout0, poe0, ext0 = '0;
    logic [15:0] pin1, pout1, poe1, ext1 = '0;

    int total = 0;
    int fails = 0;

    typedef struct {
        int          unit;
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    // Pad models: an enabled pad reads back its own drive.
    assign pin0 = (poe0 & pout0) | (~poe0 & ext0);
    assign pin1 = (poe1 & pout1) | (~poe1 & ext1);

    gpio_mmio_ctrl #(.REG_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we0),
        .bus_wdata(wdata), .bus_rdata(rdata0),
        .pad_in(pin0), .pad_out(pout0), .pad_oe(poe0)
    );

    gpio_mmio_ctrl #(.REG_W(16), .MIRROR(1'b1), .BYTE_SWAP(1'b1),
                     .HAS_CLR(1'b0), .SET_READS_LATCH(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we1),
        .bus_wdata(wdata[15:0]), .bus_rdata(rdata1),
        .pad_in(pin1), .pad_out(pout1), .pad_oe(poe1)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(int unit, logic [2:0] a, logic [31:0] d);
        @(posedge clk); #2;
        addr = a; wdata = d; we0 = (unit == 0); we1 = (unit == 1);
    endtask

    task automatic rd(int unit, logic [2:0] a, logic [31:0] e, string req);
        item_t it;
        @(posedge clk); #2;
        addr = a; we0 = 1'b0; we1 = 1'b0;
        it.unit = unit; it.exp = e; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #2;
            we0 = 1'b0; we1 = 1'b0;
        end
    endtask

    task automatic pchk(string req, logic [31:0] act, logic [31:0] exp);
        @(negedge clk);
        check(req, act, exp);
    endtask

    // Monitor: compare the read word for each queued item at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(it.req, (it.unit == 0) ? rdata0 : {16'h0, rdata1}, it.exp);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R12 reset state at the pads and in the direction views
        pchk("R12 oe", poe0, 32'h0);
        pchk("R12 out", pout0, 32'h0);
        rd(0, 3'd3, 32'h0000_0000, "R12 dirout");
        rd(0, 3'd4, 32'hFFFF_FFFF, "R7 dirin after reset");
        // R2 data register through the synchroniser
        ext0 = 32'hA5A5_1234;
        idle(3);
        rd(0, 3'd0, 32'hA5A5_1234, "R2 level read");
        // R6 / R7 direction pair
        wr(0, 3'd3, 32'h0000_FFFF);
        rd(0, 3'd4, 32'hFFFF_0000, "R7 complement");
        pchk("R6 pad_oe", poe0, 32'h0000_FFFF);
        // R3 / R4 set and clear layering
        wr(0, 3'd1, 32'h0000_00F0); idle(1);
        pchk("R3 set", pout0, 32'h0000_00F0);
        wr(0, 3'd1, 32'h0000_000F); idle(1);
        pchk("R3 zeros keep", pout0, 32'h0000_00FF);
        wr(0, 3'd2, 32'h0000_0030); idle(1);
        pchk("R4 clear", pout0, 32'h0000_00CF);
        rd(0, 3'd2, 32'h0, "R4 clear reads zero");
        idle(3);
        rd(0, 3'd0, 32'hA5A5_00CF, "R2 mixed pins");
        // R7 write through the input view
        wr(0, 3'd4, 32'hFFFF_FF00);
        rd(0, 3'd3, 32'h0000_00FF, "R7 dirin write");
        pchk("R6 pad_oe after dirin", poe0, 32'h0000_00FF);
        // R11 unmapped addresses
        wr(0, 3'd5, 32'hFFFF_FFFF); idle(1);
        pchk("R11 out kept", pout0, 32'h0000_00CF);
        pchk("R11 oe kept", poe0, 32'h0000_00FF);
        rd(0, 3'd5, 32'h0, "R11 read 5");
        rd(0, 3'd7, 32'h0, "R11 read 7");
        // R10 set read returns pins when latch read-back is off
        idle(3);
        rd(0, 3'd1, 32'hA5A5_12CF, "R10 set reads pins");

        // u1: R1 16-bit width, R8 mirror, R9 byte swap
        ext1 = 16'h1234;
        wr(1, 3'd3, 32'h0000_000F); idle(1);
        pchk("R8 R9 pad_oe", {16'h0, poe1}, 32'h0000_00F0);
        rd(1, 3'd4, 32'h0000_FFF0, "R7 R1 dirin 16");
        wr(1, 3'd1, 32'h0000_0102); idle(1);
        pchk("R8 R9 pad_out", {16'h0, pout1}, 32'h0000_8040);
        rd(1, 3'd1, 32'h0000_0102, "R10 latch read-back");
        // R5 plain output register
        wr(1, 3'd1, 32'h0000_0000); idle(1);
        pchk("R5 zero drives low", {16'h0, pout1}, 32'h0);
        wr(1, 3'd1, 32'h0000_0102); idle(1);
        wr(1, 3'd2, 32'h0000_FFFF); idle(1);
        pchk("R5 clear absent", {16'h0, pout1}, 32'h0000_8040);
        rd(1, 3'd2, 32'h0, "R5 clear unmapped read");
        idle(3);
        rd(1, 3'd0, 32'h0000_4822, "R2 R8 R9 level 16");
        idle(2);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule